// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns three reset causes into one orderly reset of the processor: a level on the shared reset pin driven from outside, a level from the supply-voltage monitor, and a one-cycle pulse from the watchdog. Once a cause is accepted, the block pulls the open-drain reset pin low for an active phase and then for a stabilisation delay. After that it releases the pin and spends two cycles presenting the reset vector address. Only then does it let the processor run.

The pin is both an input and an output. The block reads the pin level through a two-flop synchroniser and a width filter, so glitches shorter than the minimum are dropped. The block drives the pin only through a pull-down enable. A single option input chooses a short or a long stabilisation delay. A sticky flag records whether the most recent reset was caused by the watchdog. Software clears that flag with a one-cycle write strobe.

States: RUN (normal operation), ACTIVE (pin pulled low for the cause), WAIT_REL (pin released, waiting for the pin to read high), DELAY (stabilisation count, pin pulled low), FETCH (two vector-fetch cycles). Transitions:
- RUN→ACTIVE: on a supply fault, a watchdog pulse, or a recognised pin pulse.
- ACTIVE→WAIT_REL: pin cause, after the minimum output width.
- ACTIVE→DELAY: watchdog cause after the minimum output width, or supply cause when the fault clears.
- WAIT_REL→DELAY: when the synchronised pin reads high.
- DELAY→FETCH: at the end of the count.
- FETCH→RUN: after two cycles.
- Any state→ACTIVE: while the supply fault is present.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_n` is low, and on leaving it, the block is in DELAY: `pin_pd`=1, `cpu_rst`=1, `vec_fetch`=0, `wdg_flag`=0. The power-on delay counts from the cycle in which `rst_n` rises.
- R2: The DELAY phase keeps `pin_pd` and `cpu_rst` high for exactly SHORT_DLY cycles (256) when `long_delay`=0 and for exactly LONG_DLY cycles (4096) when `long_delay`=1. `pin_pd` is never high unless `cpu_rst` is high.
- R3: DELAY is followed by exactly two FETCH cycles. In these cycles `vec_fetch`=1, `cpu_rst`=1 and `pin_pd`=0, and `vec_addr` is VEC_BASE (FFFEh) in the first cycle and VEC_BASE+1 (FFFFh) in the second. After FETCH, `cpu_rst` and `vec_fetch` are 0.
- R4: In RUN, a low on `pin_in` is recognised only when the synchronised level stays low for MIN_IN (4) consecutive cycles. ACTIVE is entered two cycles after the last of those samples. A shorter low pulse leaves `cpu_rst` and `pin_pd` at 0.
- R5: A recognised pin pulse drives `pin_pd` high for exactly MIN_OUT (16) cycles, even when the pulse was shorter. The block then waits in WAIT_REL with `pin_pd`=0 and `cpu_rst`=1 until the synchronised pin reads high. It then enters DELAY; three cycles pass when the pin is already free.
- R6: When the outside source still holds the pin low after the minimum output width, DELAY does not begin until two cycles after the pin is released.
- R7: A `wdg_uflow` pulse in RUN sets `pin_pd` and `cpu_rst` from the next cycle. The block holds ACTIVE for MIN_OUT cycles and goes directly into DELAY.
- R8: While `lvd_rst`=1, the next cycle has `pin_pd`=1 and `cpu_rst`=1, in any state. An ongoing sequence is abandoned. DELAY starts from zero in the cycle after `lvd_rst` falls.
- R9: `wdg_flag` is set when a watchdog reset starts. It is cleared by a one-cycle `flag_clr` and when a pin or supply reset starts. A set in the same cycle as `flag_clr` wins.
- R10: In RUN, a supply fault takes priority over a watchdog pulse, which takes priority over the pin. A watchdog pulse outside RUN is ignored: the delay length and `wdg_flag` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Power-on reset of the sequencer, active low |
| pin_in | input | 1 | Level read back from the open-drain reset pin, asynchronous |
| lvd_rst | input | 1 | Supply-fault reset level, active high, synchronous |
| wdg_uflow | input | 1 | Watchdog underflow pulse, one cycle |
| long_delay | input | 1 | Delay select: 0 short, 1 long |
| flag_clr | input | 1 | Write strobe that clears the watchdog flag |
| pin_pd | output | 1 | Pull-down enable of the reset pin |
| cpu_rst | output | 1 | Internal processor reset, active high |
| vec_fetch | output | 1 | High during the two vector-fetch cycles |
| vec_addr | output | AW | Vector byte address during fetch, zero otherwise |
| wdg_flag | output | 1 | Last reset came from the watchdog |

## Verification
Every result has a fixed latency, counted from the posedge after an input change.

| Stimulus | When the result appears |
|---|---|
| Watchdog pulse or supply fault | Outputs change at the first edge |
| Supply fault ends | DELAY starts at the first edge after `lvd_rst` falls |
| Pin pulled low | ACTIVE starts MIN_IN+2 edges after the first low sample, through two synchroniser flops and the filter count |
| Pin released | DELAY follows three edges after the block releases the pin, or two edges after an outside release |

The bench changes inputs on the falling edge and samples on the following falling edges. It checks each phase cycle by cycle for its exact length, so a phase that runs one cycle long or short shows up at the boundary.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ACTIVE,
        ST_WAITREL,
        ST_DELAY,
        ST_FETCH
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_PIN,
        SRC_LVD,
        SRC_WDG
    } rst_src_e;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchroniser for the asynchronous pin level.
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_low_filter.sv
// Recognises a low level that persists for MIN_IN consecutive samples.
module rstseq_low_filter #(
    parameter int MIN_IN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    output logic det
);
    localparam int CW = (MIN_IN < 2) ? 1 : $clog2(MIN_IN + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_IN - 1);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!en || lvl) begin
            run_len <= '0;
        end else if (run_len != LAST) begin
            run_len <= run_len + 1'b1;
        end
    end

    assign det = en && !lvl && (run_len == LAST);
endmodule

// File: rtl/rstseq_phase_cnt.sv
// Cycle counter for the current phase, cleared on every state change.
module rstseq_phase_cnt #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [15:0] VEC_BASE  = 16'hFFFE,
    parameter int          SHORT_DLY = 256,
    parameter int          LONG_DLY  = 4096,
    parameter int          MIN_IN    = 4,
    parameter int          MIN_OUT   = 16,
    parameter int          SYNC_STG  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_in,
    input  logic          lvd_rst,
    input  logic          wdg_uflow,
    input  logic          long_delay,
    input  logic          flag_clr,
    output logic          pin_pd,
    output logic          cpu_rst,
    output logic          vec_fetch,
    output logic [AW-1:0] vec_addr,
    output logic          wdg_flag
);
    localparam int CNT_MAX = (LONG_DLY > SHORT_DLY)
                           ? ((LONG_DLY > MIN_OUT) ? LONG_DLY : MIN_OUT)
                           : ((SHORT_DLY > MIN_OUT) ? SHORT_DLY : MIN_OUT);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] OUT_LAST   = CW'(MIN_OUT - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DLY - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DLY - 1);
    localparam logic [CW-1:0] FETCH_LAST = CW'(1);

    seq_state_e    st, nxt;
    rst_src_e      src, nsrc;
    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          pin_s;
    logic          pin_det;
    logic [CW-1:0] dly_last;
    logic          flag_set, flag_kill;

    rstseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    rstseq_low_filter #(.MIN_IN(MIN_IN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st == ST_RUN),
        .lvl   (pin_s),
        .det   (pin_det)
    );

    rstseq_phase_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .q     (cnt)
    );

    assign dly_last = long_delay ? LONG_LAST : SHORT_LAST;

    // Next-state logic
    always_comb begin
        nxt  = st;
        nsrc = src;
        unique case (st)
            ST_RUN: begin
                if (wdg_uflow) begin
                    nxt  = ST_ACTIVE;
                    nsrc = SRC_WDG;
                end else if (pin_det) begin
                    nxt  = ST_ACTIVE;
                    nsrc = SRC_PIN;
                end
            end
            ST_ACTIVE: begin
                if (src == SRC_LVD) begin
                    if (!lvd_rst) nxt = ST_DELAY;
                end else if (cnt == OUT_LAST) begin
                    nxt = (src == SRC_PIN) ? ST_WAITREL : ST_DELAY;
                end
            end
            ST_WAITREL: begin
                if (pin_s) nxt = ST_DELAY;
            end
            ST_DELAY: begin
                if (cnt == dly_last) nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (cnt == FETCH_LAST) nxt = ST_RUN;
            end
            default: nxt = ST_DELAY;
        endcase
        // A supply fault overrides every state and every other cause
        if (lvd_rst) begin
            nxt  = ST_ACTIVE;
            nsrc = SRC_LVD;
        end
        cnt_clr = (nxt != st);
    end

    assign flag_set  = (st == ST_RUN) && (nxt == ST_ACTIVE) && (nsrc == SRC_WDG);
    assign flag_kill = (nxt == ST_ACTIVE) && (nsrc != SRC_WDG);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_DELAY;
            src      <= SRC_NONE;
            wdg_flag <= 1'b0;
        end else begin
            st  <= nxt;
            src <= nsrc;
            if (flag_set) begin
                wdg_flag <= 1'b1;
            end else if (flag_kill || flag_clr) begin
                wdg_flag <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        pin_pd    = 1'b0;
        cpu_rst   = 1'b1;
        vec_fetch = 1'b0;
        vec_addr  = '0;
        unique case (st)
            ST_RUN:     cpu_rst = 1'b0;
            ST_ACTIVE:  pin_pd  = 1'b1;
            ST_WAITREL: pin_pd  = 1'b0;
            ST_DELAY:   pin_pd  = 1'b1;
            ST_FETCH: begin
                vec_fetch = 1'b1;
                vec_addr  = AW'(VEC_BASE) + AW'(cnt[0]);
            end
            default: pin_pd = 1'b1;
        endcase
    end
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int          AW       = 16,
    parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lvd_rst,
    input logic          wdg_uflow,
    input logic          flag_clr,
    input logic          pin_pd,
    input logic          cpu_rst,
    input logic          vec_fetch,
    input logic [AW-1:0] vec_addr,
    input logic          wdg_flag
);
    p_pd_needs_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pd |-> cpu_rst);

    p_fetch_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_fetch) |=> vec_fetch);

    p_fetch_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && $past(vec_fetch)) |=> !vec_fetch);

    p_fetch_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_fetch) |-> (vec_addr == AW'(VEC_BASE)));

    p_fetch_pin_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |-> (cpu_rst && !pin_pd));

    p_lvd_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_rst |=> (cpu_rst && pin_pd));

    p_wdg_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_uflow && !cpu_rst && !lvd_rst) |=> wdg_flag);

    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !wdg_uflow) |=> !wdg_flag);
endmodule

bind reset_sequencer rstseq_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvd_rst   (lvd_rst),
    .wdg_uflow (wdg_uflow),
    .flag_clr  (flag_clr),
    .pin_pd    (pin_pd),
    .cpu_rst   (cpu_rst),
    .vec_fetch (vec_fetch),
    .vec_addr  (vec_addr),
    .wdg_flag  (wdg_flag)
);

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;
    localparam int MIN_IN  = 4;
    localparam int MIN_OUT = 16;
    localparam int SHORT   = 256;
    localparam int LONG    = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_low = 1'b0;
    logic lvd_rst = 1'b0;
    logic wdg_uflow = 1'b0;
    logic long_delay = 1'b0;
    logic flag_clr = 1'b0;
    logic pin_pd, cpu_rst, vec_fetch, wdg_flag;
    logic [15:0] vec_addr;
    logic pin_lvl;
    logic [2:0] obs;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // Open-drain pin: low if either side pulls it down
    assign pin_lvl = !(ext_low || pin_pd);
    assign obs = {pin_pd, cpu_rst, vec_fetch};

    reset_sequencer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_lvl),
        .lvd_rst    (lvd_rst),
        .wdg_uflow  (wdg_uflow),
        .long_delay (long_delay),
        .flag_clr   (flag_clr),
        .pin_pd     (pin_pd),
        .cpu_rst    (cpu_rst),
        .vec_fetch  (vec_fetch),
        .vec_addr   (vec_addr),
        .wdg_flag   (wdg_flag)
    );

    task automatic check_bit(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Checks {pin_pd,cpu_rst,vec_fetch} on each of the next n falling edges
    task automatic check_seg(input logic [2:0] e, input int n, input string tag);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ok && obs !== e) begin
                ok = 1'b0;
                $display("FAIL %s: cycle %0d obs=%b expected=%b", tag, i, obs, e);
            end
        end
        total++;
        if (!ok) bad++;
    endtask

    task automatic check_fetch(input string tag);
        bit ok = 1'b1;
        @(negedge clk);
        if (obs !== 3'b011 || vec_addr !== 16'hFFFE) begin
            ok = 1'b0;
            $display("FAIL %s: fetch1 obs=%b addr=%h expected=011 FFFE", tag, obs, vec_addr);
        end
        @(negedge clk);
        if (obs !== 3'b011 || vec_addr !== 16'hFFFF) begin
            ok = 1'b0;
            $display("FAIL %s: fetch2 obs=%b addr=%h expected=011 FFFF", tag, obs, vec_addr);
        end
        @(negedge clk);
        if (obs !== 3'b000) begin
            ok = 1'b0;
            $display("FAIL %s: after fetch obs=%b expected=000", tag, obs);
        end
        total++;
        if (!ok) bad++;
    endtask

    task automatic t_power_on();
        repeat (3) @(negedge clk);
        check_bit(pin_pd, 1'b1, "R1 pd in reset");
        check_bit(cpu_rst, 1'b1, "R1 cpu_rst in reset");
        check_bit(wdg_flag, 1'b0, "R1 flag in reset");
        rst_n = 1'b1;
        check_seg(3'b110, SHORT - 1, "R1 R2 power-on delay");
        check_fetch("R3 power-on fetch");
        check_seg(3'b000, 5, "R1 run after power-on");
    endtask

    task automatic t_wdg();
        wdg_uflow = 1'b1;
        @(negedge clk);
        wdg_uflow = 1'b0;
        check_bit(pin_pd, 1'b1, "R7 pd after watchdog");
        check_bit(wdg_flag, 1'b1, "R9 flag set by watchdog");
        check_seg(3'b110, MIN_OUT + SHORT - 1, "R7 R2 watchdog active+delay");
        check_fetch("R3 watchdog fetch");
        check_bit(wdg_flag, 1'b1, "R9 flag held");
    endtask

    task automatic t_flag_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check_bit(wdg_flag, 1'b0, "R9 flag cleared by write");
        check_seg(3'b000, 3, "R9 clear has no reset effect");
    endtask

    task automatic t_set_beats_clr();
        wdg_uflow = 1'b1;
        flag_clr  = 1'b1;
        @(negedge clk);
        wdg_uflow = 1'b0;
        flag_clr  = 1'b0;
        check_bit(wdg_flag, 1'b1, "R9 set wins over clear");
        check_seg(3'b110, MIN_OUT + SHORT - 1, "R7 second watchdog");
        check_fetch("R3 second watchdog fetch");
    endtask

    task automatic t_ext_short();
        ext_low = 1'b1;
        repeat (MIN_IN - 1) @(negedge clk);
        ext_low = 1'b0;
        check_seg(3'b000, 12, "R4 short pulse ignored");
    endtask

    task automatic t_ext_min();
        ext_low = 1'b1;
        check_seg(3'b000, MIN_IN, "R4 before recognition");
        ext_low = 1'b0;
        check_seg(3'b000, 1, "R4 recognition latency");
        check_seg(3'b110, MIN_OUT, "R5 stretched output");
        check_seg(3'b010, 3, "R5 wait for release");
        check_seg(3'b110, SHORT, "R2 delay after pin");
        check_fetch("R3 pin fetch");
        check_bit(wdg_flag, 1'b0, "R9 pin reset clears flag");
    endtask

    task automatic t_ext_long();
        ext_low = 1'b1;
        check_seg(3'b000, MIN_IN + 1, "R4 long pulse recognition");
        check_seg(3'b110, MIN_OUT, "R5 active on long pulse");
        check_seg(3'b010, 10, "R6 held by outside source");
        ext_low = 1'b0;
        check_seg(3'b010, 2, "R6 release latency");
        check_seg(3'b110, SHORT, "R6 delay after release");
        check_fetch("R3 long pulse fetch");
    endtask

    task automatic t_lvd();
        lvd_rst = 1'b1;
        check_seg(3'b110, 20, "R8 static supply reset");
        lvd_rst = 1'b0;
        check_seg(3'b110, SHORT, "R8 delay after supply fault");
        check_fetch("R3 supply fetch");
    endtask

    task automatic t_lvd_preempt();
        wdg_uflow = 1'b1;
        @(negedge clk);
        wdg_uflow = 1'b0;
        check_seg(3'b110, MIN_OUT + 99, "R7 watchdog before preempt");
        lvd_rst = 1'b1;
        check_seg(3'b110, 5, "R8 preempt");
        lvd_rst = 1'b0;
        check_seg(3'b110, SHORT, "R8 delay restarts from zero");
        check_fetch("R3 preempt fetch");
        check_bit(wdg_flag, 1'b0, "R9 supply reset clears flag");
    endtask

    task automatic t_priority();
        lvd_rst   = 1'b1;
        wdg_uflow = 1'b1;
        @(negedge clk);
        wdg_uflow = 1'b0;
        check_bit(wdg_flag, 1'b0, "R10 supply beats watchdog");
        check_seg(3'b110, 3, "R10 supply style hold");
        lvd_rst = 1'b0;
        check_seg(3'b110, 100, "R10 delay first part");
        wdg_uflow = 1'b1;
        check_seg(3'b110, 1, "R10 watchdog in delay");
        wdg_uflow = 1'b0;
        check_seg(3'b110, SHORT - 101, "R10 delay not extended");
        check_fetch("R10 fetch on time");
        check_bit(wdg_flag, 1'b0, "R10 flag unchanged in reset");
    endtask

    task automatic t_long_delay();
        long_delay = 1'b1;
        wdg_uflow = 1'b1;
        @(negedge clk);
        wdg_uflow = 1'b0;
        check_seg(3'b110, MIN_OUT + LONG - 1, "R2 long delay");
        check_fetch("R3 long delay fetch");
        long_delay = 1'b0;
    endtask

    initial begin
        t_power_on();
        t_wdg();
        t_flag_clr();
        t_set_beats_clr();
        t_ext_short();
        t_ext_min();
        t_ext_long();
        t_lvd();
        t_lvd_preempt();
        t_priority();
        t_long_delay();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule